// File: doc/BRIEF.md
# Inference Accelerator Control Register Slave

This block is the host-facing control port of a single-shot image classification engine. A processor on an AXI4-Lite bus programs the location of the input image, launches one inference, learns when it has finished, and then reads the predicted class. On the engine side, the block issues a one-cycle launch strobe and presents the image base address to the memory-fetch master, which reads 3072 elements (32×32×3) starting at that address. The block then waits for the engine's completion pulse, which carries a 4-bit class index in the range 0 to 9.

The host sees a status word with four bits: start pending, done, idle and ready. The done bit is sticky. It is set by the completion pulse and cleared when the host reads the status word, so a polling host cannot miss a completion that lasts only one cycle. The same sticky bit is also brought out as a level for an interrupt line. The address given to the fetch master is frozen at launch, so the host may reprogram the base register for the next image while the current run is still in progress.

Top module: `accel_ctrl_slave`

## Requirements
- R1: After reset the status word at offset 0x00 reads 0xC: bit0 start=0, bit1 done=0, bit2 idle=1, bit3 ready=1. At the same point core_start is 0, img_base is 0, the base register (0x10) reads 0, the result register (0x18) reads 0 and done_irq is 0.
- R2: A write of 1 to bit0 of offset 0x00 with byte lane 0 enabled, issued while idle, produces exactly one core_start pulse one cycle wide. After that pulse, the status word reads 0x0: the start bit has cleared itself, and idle and ready are low.
- R3: The base register at offset 0x10 is read/write. Each byte lane is written only when its WSTRB bit is set. At launch, img_base takes the register's value.
- R4: A core_done pulse while busy loads core_class into bits [3:0] of offset 0x18 and sets done, idle and ready. The status word then reads 0xE.
- R5: The done bit stays set until the host reads offset 0x00. That read returns done=1 and clears the bit, so the next read returns 0xC. done_irq follows the done bit.
- R6: A core_done pulse while idle changes neither the result register nor the status word. The result keeps its value until the next completion of a launched run.
- R7: A start write while busy is ignored. It produces no core_start pulse, neither during the run nor after it finishes.
- R8: A base register write while busy updates the register as read at 0x10 but leaves img_base unchanged until the next launch.
- R9: Every write and read response is OKAY (2'b00). Reads of unmapped offsets such as 0x04, 0x08 and 0x1C return 0. Writes to unmapped offsets or to the read-only result register have no effect.
- R10: The address and data of a write may arrive in either order and in different cycles. Each write produces exactly one write response, and a pending response or read data is held stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_start | output | 1 | One-cycle launch strobe to the engine |
| img_base | output | 32 | Image base address frozen at launch |
| core_done | input | 1 | Completion pulse from the engine |
| core_class | input | CLS_W | Predicted class, valid with core_done |
| done_irq | output | 1 | Level copy of the sticky done bit |

## Verification
The embedded properties check these rules on every cycle: the launch strobe is a single-cycle pulse that can only leave the idle state; the done bit rises only on a completion pulse and falls only on a status read; the result register changes only on completion; the frozen address stays put for the whole of a run; and responses on both channels stay stable while they wait to be accepted. Some behaviour can only be shown by the bench's scenarios, because it depends on the values the host sees: the exact status encodings, the byte-lane merging of the base register, that a start issued while busy leaves no hidden pending launch behind it, the read-to-clear sequence, and that writes reach the registers correctly whatever the order of the address and data phases.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;

    localparam int AXI_DW  = 32;
    localparam int STRB_W  = AXI_DW / 8;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // word indices (byte offset >> 2)
    localparam int IDX_STATUS = 0;   // 0x00
    localparam int IDX_BASE   = 4;   // 0x10
    localparam int IDX_RESULT = 6;   // 0x18

    // status word bit positions
    localparam int SB_START = 0;
    localparam int SB_DONE  = 1;
    localparam int SB_IDLE  = 2;
    localparam int SB_READY = 3;

    function automatic logic [AXI_DW-1:0] apply_strb(
        input logic [AXI_DW-1:0] old_w,
        input logic [AXI_DW-1:0] new_w,
        input logic [STRB_W-1:0] strb
    );
        logic [AXI_DW-1:0] r;
        r = old_w;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/axil_wr_port.sv
module axil_wr_port
    import accel_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [AXI_DW-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [AXI_DW-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);

    typedef struct packed {
        logic              aw_full;
        logic              w_full;
        logic [ADDR_W-1:0] addr;
        logic [AXI_DW-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              bvalid;
    } wr_state_t;

    wr_state_t wr_d, wr_q;
    logic      fire;

    always_comb begin
        wr_d = wr_q;
        fire = wr_q.aw_full && wr_q.w_full && !wr_q.bvalid;
        if (awvalid && !wr_q.aw_full) begin
            wr_d.aw_full = 1'b1;
            wr_d.addr    = awaddr;
        end
        if (wvalid && !wr_q.w_full) begin
            wr_d.w_full = 1'b1;
            wr_d.data   = wdata;
            wr_d.strb   = wstrb;
        end
        if (fire) begin
            wr_d.aw_full = 1'b0;
            wr_d.w_full  = 1'b0;
            wr_d.bvalid  = 1'b1;
        end
        if (wr_q.bvalid && bready) begin
            wr_d.bvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign awready = !wr_q.aw_full;
    assign wready  = !wr_q.w_full;
    assign bvalid  = wr_q.bvalid;
    assign bresp   = RESP_OKAY;
    assign wr_en   = fire;
    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;
    assign wr_strb = wr_q.strb;

    // R10
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R10
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!wr_en && bvalid));

endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port
    import accel_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [AXI_DW-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [AXI_DW-1:0] rd_word
);

    typedef struct packed {
        logic              rvalid;
        logic [AXI_DW-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d    = rd_q;
        rd_fire = arvalid && !rd_q.rvalid;
        if (rd_q.rvalid && rready) begin
            rd_d.rvalid = 1'b0;
        end
        if (rd_fire) begin
            rd_d.rvalid = 1'b1;
            rd_d.rdata  = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign arready = !rd_q.rvalid;
    assign rvalid  = rd_q.rvalid;
    assign rdata   = rd_q.rdata;
    assign rresp   = RESP_OKAY;
    assign rd_addr = araddr;

    // R10
    r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

// File: rtl/hs_regfile.sv
module hs_regfile
    import accel_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CLS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [AXI_DW-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [AXI_DW-1:0] rd_word,
    input  logic              core_done,
    input  logic [CLS_W-1:0]  core_class,
    output logic              core_start,
    output logic [AXI_DW-1:0] img_base,
    output logic              done_irq
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_STATUS = WORD_W'(IDX_STATUS);
    localparam logic [WORD_W-1:0] W_BASE   = WORD_W'(IDX_BASE);
    localparam logic [WORD_W-1:0] W_RESULT = WORD_W'(IDX_RESULT);

    typedef struct packed {
        logic              start;
        logic              idle;
        logic              done;
        logic              launch;
        logic [AXI_DW-1:0] base;
        logic [AXI_DW-1:0] run_base;
        logic [CLS_W-1:0]  result;
    } hs_state_t;

    hs_state_t hs_d, hs_q;

    logic [WORD_W-1:0] wr_idx, rd_idx;
    logic              ready_now;
    logic              unused_lsb;

    assign wr_idx     = wr_addr[ADDR_W-1:2];
    assign rd_idx     = rd_addr[ADDR_W-1:2];
    assign unused_lsb = ^{wr_addr[1:0], rd_addr[1:0]};
    assign ready_now  = hs_q.idle && !hs_q.start;

    always_comb begin
        hs_d        = hs_q;
        hs_d.launch = 1'b0;

        // pending start accepted by an idle engine
        if (hs_q.start && hs_q.idle) begin
            hs_d.start    = 1'b0;
            hs_d.launch   = 1'b1;
            hs_d.idle     = 1'b0;
            hs_d.run_base = hs_q.base;
        end

        // host read of the status word clears the sticky done
        if (rd_fire && rd_idx == W_STATUS) begin
            hs_d.done = 1'b0;
        end

        // completion (set has priority over a same-cycle clear)
        if (core_done && !hs_q.idle) begin
            hs_d.result = core_class;
            hs_d.done   = 1'b1;
            hs_d.idle   = 1'b1;
        end

        if (wr_en) begin
            if (wr_idx == W_STATUS) begin
                if (wr_strb[0] && wr_data[SB_START] && ready_now) begin
                    hs_d.start = 1'b1;
                end
            end else if (wr_idx == W_BASE) begin
                hs_d.base = apply_strb(hs_q.base, wr_data, wr_strb);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q      <= '0;
            hs_q.idle <= 1'b1;
        end else begin
            hs_q <= hs_d;
        end
    end

    always_comb begin
        rd_word = '0;
        if (rd_idx == W_STATUS) begin
            rd_word[SB_START] = hs_q.start;
            rd_word[SB_DONE]  = hs_q.done;
            rd_word[SB_IDLE]  = hs_q.idle;
            rd_word[SB_READY] = ready_now;
        end else if (rd_idx == W_BASE) begin
            rd_word = hs_q.base;
        end else if (rd_idx == W_RESULT) begin
            rd_word[CLS_W-1:0] = hs_q.result;
        end
    end

    assign core_start = hs_q.launch;
    assign img_base   = hs_q.run_base;
    assign done_irq   = hs_q.done;

    // R2
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R2
    launch_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_start) |-> ($past(hs_q.idle) && !hs_q.idle));

    // R4
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> $past(core_done));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_irq) |-> $past(rd_fire));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(core_done) |-> $stable(hs_q.result));

    // R8
    run_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_q.idle && !$past(hs_q.idle)) |-> $stable(img_base));

endmodule

// File: rtl/accel_ctrl_slave.sv
module accel_ctrl_slave
    import accel_ctrl_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CLS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              core_start,
    output logic [31:0]       img_base,
    input  logic              core_done,
    input  logic [CLS_W-1:0]  core_class,
    output logic              done_irq
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [AXI_DW-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic              rd_fire;
    logic [ADDR_W-1:0] rd_addr;
    logic [AXI_DW-1:0] rd_word;

    axil_wr_port #(.ADDR_W(ADDR_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    axil_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rd_fire (rd_fire),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    hs_regfile #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_strb    (wr_strb),
        .rd_fire    (rd_fire),
        .rd_addr    (rd_addr),
        .rd_word    (rd_word),
        .core_done  (core_done),
        .core_class (core_class),
        .core_start (core_start),
        .img_base   (img_base),
        .done_irq   (done_irq)
    );

endmodule

// File: tb/accel_ctrl_slave_bench.sv
module accel_ctrl_slave_bench;

    localparam int ADDR_W = 5;
    localparam int CLS_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [1:0]        s_bresp;
    logic              s_bvalid;
    logic              s_bready = 1'b1;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b1;
    logic              core_start;
    logic [31:0]       img_base;
    logic              core_done = 1'b0;
    logic [CLS_W-1:0]  core_class = '0;
    logic              done_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int n_starts = 0;
    logic [1:0] last_bresp;

    always #2.5 clk = ~clk;

    accel_ctrl_slave #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_accel_ctrl_slave (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .core_start(core_start), .img_base(img_base),
        .core_done(core_done), .core_class(core_class), .done_irq(done_irq)
    );

    // each negedge with core_start high counts one cycle of strobe
    always @(negedge clk) if (rst_n && core_start) n_starts++;

    function automatic logic [31:0] status_word(bit st, bit dn, bit id, bit rd);
        return {28'd0, rd, id, dn, st};
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             input logic [3:0] st, input int aw_dly, input int w_dly);
        bit aw_done = 0;
        bit w_done  = 0;
        int c = 0;
        while (!(aw_done && w_done)) begin
            bit aw_fire, w_fire;
            s_awaddr  = a;
            s_wdata   = d;
            s_wstrb   = st;
            s_awvalid = !aw_done && (c >= aw_dly);
            s_wvalid  = !w_done && (c >= w_dly);
            aw_fire   = s_awvalid && s_awready;
            w_fire    = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_fire) aw_done = 1;
            if (w_fire)  w_done  = 1;
            c++;
        end
        s_awvalid = 1'b0;
        s_wvalid  = 1'b0;
        while (!s_bvalid) @(negedge clk);
        last_bresp = s_bresp;
        @(negedge clk);
    endtask

    task automatic axi_read(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic [1:0] rs);
        bit fire = 0;
        s_araddr  = a;
        s_arvalid = 1'b1;
        while (!fire) begin
            fire = s_arvalid && s_arready;
            @(negedge clk);
        end
        s_arvalid = 1'b0;
        d  = s_rdata;
        rs = s_rresp;
        @(negedge clk);
    endtask

    task automatic pulse_done(input logic [CLS_W-1:0] cls);
        core_done  = 1'b1;
        core_class = cls;
        @(negedge clk);
        core_done  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd, base_m, run_m;
        logic [1:0]  rs;
        logic [3:0]  res_m;
        int          s0;

        void'($urandom(32'd20240611));
        base_m = '0;
        run_m  = '0;
        res_m  = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(core_start == 1'b0, "R1 core_start", {31'd0, core_start}, 32'd0);
        check(img_base == 32'd0, "R1 img_base", img_base, 32'd0);
        check(done_irq == 1'b0, "R1 done_irq", {31'd0, done_irq}, 32'd0);
        axi_read(5'h00, rd, rs);
        check(rd == status_word(0, 0, 1, 1), "R1 status", rd, status_word(0, 0, 1, 1));
        check(rs == 2'b00, "R9 rresp", {30'd0, rs}, 32'd0);
        axi_read(5'h10, rd, rs);
        check(rd == 32'd0, "R1 base", rd, 32'd0);
        axi_read(5'h18, rd, rs);
        check(rd == 32'd0, "R1 result", rd, 32'd0);

        // R3 byte lanes
        axi_write(5'h10, 32'hFFFF_FFFF, 4'hF, 0, 0);
        check(last_bresp == 2'b00, "R9 bresp", {30'd0, last_bresp}, 32'd0);
        axi_write(5'h10, 32'h0000_0000, 4'b0101, 0, 0);
        base_m = 32'hFF00_FF00;
        axi_read(5'h10, rd, rs);
        check(rd == base_m, "R3 strb merge", rd, base_m);

        // R9 unmapped and read-only
        axi_write(5'h08, 32'hDEAD_BEEF, 4'hF, 0, 0);
        axi_write(5'h18, 32'h0000_0007, 4'hF, 0, 0);
        axi_read(5'h08, rd, rs);
        check(rd == 32'd0, "R9 unmapped 0x08", rd, 32'd0);
        axi_read(5'h04, rd, rs);
        check(rd == 32'd0, "R9 unmapped 0x04", rd, 32'd0);
        axi_read(5'h1C, rd, rs);
        check(rd == 32'd0, "R9 unmapped 0x1C", rd, 32'd0);
        axi_read(5'h18, rd, rs);
        check(rd == 32'd0, "R9 result read-only", rd, 32'd0);

        // R6 done while idle ignored
        pulse_done(4'd5);
        idle_cycles(2);
        axi_read(5'h18, rd, rs);
        check(rd == 32'd0, "R6 idle done result", rd, 32'd0);
        axi_read(5'h00, rd, rs);
        check(rd == status_word(0, 0, 1, 1), "R6 idle done status", rd, status_word(0, 0, 1, 1));

        // start with byte lane 0 disabled does nothing (R2 lane rule)
        s0 = n_starts;
        axi_write(5'h00, 32'h1, 4'b1110, 0, 0);
        idle_cycles(3);
        check(n_starts == s0, "R2 lane0 off", n_starts, s0);

        // directed run with busy start and busy base write
        s0 = n_starts;
        axi_write(5'h00, 32'h1, 4'b0001, 1, 0);
        idle_cycles(3);
        run_m = base_m;
        check(n_starts == s0 + 1, "R2 single pulse", n_starts, s0 + 1);
        check(img_base == run_m, "R3 img_base launch", img_base, run_m);
        axi_read(5'h00, rd, rs);
        check(rd == status_word(0, 0, 0, 0), "R2 busy status", rd, status_word(0, 0, 0, 0));
        axi_write(5'h00, 32'h1, 4'hF, 0, 0);
        axi_write(5'h10, 32'h1234_5678, 4'hF, 0, 2);
        base_m = 32'h1234_5678;
        idle_cycles(3);
        check(n_starts == s0 + 1, "R7 busy start", n_starts, s0 + 1);
        check(img_base == run_m, "R8 img_base frozen", img_base, run_m);
        axi_read(5'h10, rd, rs);
        check(rd == base_m, "R8 base reg updated", rd, base_m);
        pulse_done(4'd9);
        res_m = 4'd9;
        idle_cycles(4);
        check(n_starts == s0 + 1, "R7 no late launch", n_starts, s0 + 1);
        check(done_irq == 1'b1, "R5 done_irq", {31'd0, done_irq}, 32'd1);
        axi_read(5'h00, rd, rs);
        check(rd == status_word(0, 1, 1, 1), "R4 done status", rd, status_word(0, 1, 1, 1));
        axi_read(5'h00, rd, rs);
        check(rd == status_word(0, 0, 1, 1), "R5 cleared", rd, status_word(0, 0, 1, 1));
        check(done_irq == 1'b0, "R5 irq cleared", {31'd0, done_irq}, 32'd0);
        axi_read(5'h18, rd, rs);
        check(rd == {28'd0, res_m}, "R4 result", rd, {28'd0, res_m});
        pulse_done(4'd2);
        idle_cycles(2);
        axi_read(5'h18, rd, rs);
        check(rd == {28'd0, res_m}, "R6 result kept", rd, {28'd0, res_m});

        // random runs
        for (int it = 0; it < 24; it++) begin
            logic [31:0] nb;
            logic [3:0]  ns;
            logic [3:0]  cls;
            int          awd, wd, busy;
            nb   = $urandom;
            ns   = 4'($urandom);
            cls  = 4'($urandom % 10);
            awd  = int'($urandom % 3);
            wd   = int'($urandom % 3);
            busy = int'($urandom % 6);
            axi_write(5'h10, nb, ns, awd, wd);
            base_m = merge(base_m, nb, ns);
            axi_read(5'h10, rd, rs);
            check(rd == base_m, "R10 base order", rd, base_m);
            s0 = n_starts;
            axi_write(5'h00, 32'h1, 4'h1, wd, awd);
            idle_cycles(3);
            run_m = base_m;
            check(n_starts == s0 + 1, "R2 rand pulse", n_starts, s0 + 1);
            check(img_base == run_m, "R3 rand img_base", img_base, run_m);
            if (busy > 2) begin
                nb = $urandom;
                axi_write(5'h10, nb, 4'hF, 0, 0);
                base_m = nb;
                check(img_base == run_m, "R8 rand frozen", img_base, run_m);
            end
            idle_cycles(busy);
            pulse_done(cls);
            res_m = cls;
            idle_cycles(2);
            axi_read(5'h00, rd, rs);
            check(rd == status_word(0, 1, 1, 1), "R5 rand done", rd, status_word(0, 1, 1, 1));
            check(rs == 2'b00, "R9 rand rresp", {30'd0, rs}, 32'd0);
            axi_read(5'h00, rd, rs);
            check(rd == status_word(0, 0, 1, 1), "R5 rand clear", rd, status_word(0, 0, 1, 1));
            axi_read(5'h18, rd, rs);
            check(rd == {28'd0, res_m}, "R4 rand result", rd, {28'd0, res_m});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule